// File: doc/BRIEF.md
# SD Data Transfer Block Sequencer

This block follows a multi-block data transfer on an SD/MMC host. Software programs a block size and a data control word holding the block count, a 2-bit transfer mode and a stop bit. The control word also holds three "arm" bits, one for each mode. With the arm bit of the chosen mode clear, writing the control word starts the transfer at once. With it set, the transfer waits for the next command-completion pulse.

While a receive or transmit transfer runs, every pulse on `byte_strobe` stands for one byte moved between the card byte stream and the local FIFO. The block counts these bytes, reloads the byte counter at each block boundary and, once the last block is used up, drops the run flag and sets a sticky finished status. That status drives the interrupt through a mask bit. A remaining-count register reports both counters. A busy-wait mode holds the run flag without counting, until software stops it.

Top module: `sdx_seq`

## Requirements
- R1: After a synchronous active-low reset, the remaining count, status and mask read 0, the timer register reads 0x2000, and `xfer_run` and `irq` are low.
- R2: Register addresses are: 0 block size (keeps bits [11:0] of the write), 1 data control, 2 remaining count (read only), 3 status, 4 mask, 5 timer (keeps bits [15:0]). Unmapped addresses read 0.
- R3: A data control write with mode bits [13:12] set to 1, 2 or 3, stop bit 14 clear and that mode's arm bit clear starts the transfer in the cycle after the write. The arm bits are bit 18 for mode 1, bit 19 for mode 2 and bit 20 for mode 3. The start loads the byte counter from the block size and the block counter from bits [11:0] of the written word.
- R4: If the selected arm bit is set, the data control write does not start the transfer. A later `cmd_done` pulse starts it and loads the counters.
- R5: A `cmd_done` pulse always loads the byte counter from the block size and the block counter from data control bits [11:0]. It starts nothing when the mode is 0 or the arm bit is clear.
- R6: In receive (2) or transmit (3) mode, each `byte_strobe` cycle of a running transfer decrements a nonzero byte counter. When the byte counter goes from 1 to 0, the block counter decrements, and if blocks remain the byte counter reloads with the block size.
- R7: The remaining-count register reads the byte counter in bits [11:0] and the block counter in bits [23:12].
- R8: A running receive or transmit transfer whose byte counter is 0 ends at the next clock edge: `xfer_run` drops and status bit 4 sets. This includes a transfer started with a block size of 0.
- R9: `irq` is high exactly while status bit 4 and mask bit 7 are both set.
- R10: Status bit 0 is set while a receive or transmit transfer runs. Status bit 1 is set while a busy-wait (mode 1) transfer runs.
- R11: A status write clears bit 4 when that written bit is 1. Written ones in other positions leave bit 4 unchanged.
- R12: A data control write with bit 14 set stops the transfer even if the same word would start one. The counters hold their values and status bit 4 does not set.
- R13: Byte strobes change nothing while no transfer runs or while the mode is busy-wait, and a busy-wait transfer never ends by itself.
- R14: A data control write with mode 0 never starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| cmd_done | input | 1 | One-cycle pulse: a command has completed |
| byte_strobe | input | 1 | One byte moved this cycle |
| xfer_run | output | 1 | Transfer running |
| irq | output | 1 | Masked data-finished interrupt |

## Verification
Receive mode is run with two blocks of three bytes, so the readback is seen both at the block boundary reload and at the final zero. Transmit mode is started after a command, then stopped mid-block. This separates the deferred start path from the immediate one, and a clean stop from a finish. Busy-wait mode is fed strobes to show that it ignores them. A zero block size, a mode-0 control write and a command pulse with no arm bit each exercise a start or load path on its own. Together they show which of the write path or the command path loads the counters.

// File: rtl/sdx_pkg.sv
// Shared types and constants for the SD data transfer block sequencer.
// Assumes: register addresses and status bit positions are fixed by software.
package sdx_pkg;

    typedef enum logic [1:0] {
        XM_OFF  = 2'd0,
        XM_BUSY = 2'd1,
        XM_RX   = 2'd2,
        XM_TX   = 2'd3
    } xmode_e;

    localparam int A_BSIZE  = 0;
    localparam int A_DCTRL  = 1;
    localparam int A_REMAIN = 2;
    localparam int A_STAT   = 3;
    localparam int A_MASK   = 4;
    localparam int A_TIMER  = 5;

    localparam int ST_RUN_DATA  = 0;
    localparam int ST_RUN_BUSY  = 1;
    localparam int ST_DONE      = 4;
    localparam int ST_W         = 10;
    localparam int IRQ_MASK_BIT = 7;

    // Pick the start-after-command bit that belongs to a mode.
    function automatic logic pick_arm(xmode_e m, logic [2:0] arms);
        case (m)
            XM_BUSY: pick_arm = arms[0];
            XM_RX:   pick_arm = arms[1];
            XM_TX:   pick_arm = arms[2];
            default: pick_arm = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sdx_regs.sv
// Register file and read mux for the transfer sequencer.
// Assumes: a single write port and a combinational read port; the status
// register lives in the controller and is only muxed here.
module sdx_regs
    import sdx_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 3,
    parameter int LEN_W   = 12,
    parameter int CNT_W   = 12,
    parameter int TMR_W   = 16,
    parameter int TMR_RST = 'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic [LEN_W-1:0]  remain_byte,
    input  logic [CNT_W-1:0]  remain_blk,
    input  logic [ST_W-1:0]   status,
    output logic [LEN_W-1:0]  bsize,
    output logic [DW-1:0]     dctrl,
    output logic [DW-1:0]     mask,
    output logic [DW-1:0]     rd_data
);

    logic [TMR_W-1:0] tmr;

    // Holds the software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsize <= '0;
            dctrl <= '0;
            mask  <= '0;
            tmr   <= TMR_W'(TMR_RST);
        end else if (wr_en) begin
            case (int'(wr_addr))
                A_BSIZE: bsize <= wr_data[LEN_W-1:0];
                A_DCTRL: dctrl <= wr_data;
                A_MASK:  mask  <= wr_data;
                A_TIMER: tmr   <= wr_data[TMR_W-1:0];
                default: ;
            endcase
        end
    end

    // Selects the register seen on the read port.
    always_comb begin
        rd_data = '0;
        case (int'(rd_addr))
            A_BSIZE:  rd_data[LEN_W-1:0]       = bsize;
            A_DCTRL:  rd_data                  = dctrl;
            A_REMAIN: rd_data[LEN_W+CNT_W-1:0] = {remain_blk, remain_byte};
            A_STAT:   rd_data[ST_W-1:0]        = status;
            A_MASK:   rd_data                  = mask;
            A_TIMER:  rd_data[TMR_W-1:0]       = tmr;
            default:  rd_data                  = '0;
        endcase
    end

endmodule

// File: rtl/sdx_ctrl.sv
// Start/stop decision and finished flag for the transfer sequencer.
// Assumes: the caller has already decoded mode, stop and arm bits, both from
// the word being written and from the stored control word.
module sdx_ctrl
    import sdx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dctrl_wr,
    input  xmode_e wr_mode,
    input  logic   wr_stop,
    input  logic   wr_armed,
    input  xmode_e cur_mode,
    input  logic   cur_armed,
    input  logic   cmd_done,
    input  logic   byte_zero,
    input  logic   stat_clr,
    output logic   active,
    output logic   load,
    output logic   load_from_wr,
    output logic   done
);

    logic start_now, start_cmd, data_mode, finish;

    // Decides the start, load and finish events of this cycle.
    always_comb begin
        start_now    = dctrl_wr && !wr_stop && (wr_mode != XM_OFF) && !wr_armed;
        start_cmd    = cmd_done && !dctrl_wr && (cur_mode != XM_OFF) && cur_armed;
        data_mode    = (cur_mode == XM_RX) || (cur_mode == XM_TX);
        finish       = active && data_mode && byte_zero && !dctrl_wr && !cmd_done;
        load         = start_now || cmd_done;
        load_from_wr = start_now;
    end

    // Tracks whether a transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n)         active <= 1'b0;
        else if (dctrl_wr)  active <= start_now;
        else if (start_cmd) active <= 1'b1;
        else if (finish)    active <= 1'b0;
    end

    // Sticky finished flag, cleared by a write-one to its status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      done <= 1'b0;
        else if (finish) done <= 1'b1;
        else if (stat_clr) done <= 1'b0;
    end

endmodule

// File: rtl/sdx_counters.sv
// Byte and block counters for the transfer sequencer.
// Assumes: load has priority over step; step is only raised in a data mode.
module sdx_counters #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             step,
    output logic [LEN_W-1:0] byte_cnt,
    output logic [CNT_W-1:0] blk_cnt,
    output logic             byte_zero
);

    assign byte_zero = (byte_cnt == '0);

    // Counts bytes down and reloads at block boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt <= '0;
            blk_cnt  <= '0;
        end else if (load) begin
            byte_cnt <= len_in;
            blk_cnt  <= cnt_in;
        end else if (step && !byte_zero) begin
            if (byte_cnt == LEN_W'(1)) begin
                blk_cnt  <= (blk_cnt != '0) ? blk_cnt - CNT_W'(1) : '0;
                byte_cnt <= (blk_cnt > CNT_W'(1)) ? len_in : '0;
            end else begin
                byte_cnt <= byte_cnt - LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdx_seq.sv
// Top of the SD data transfer block sequencer: joins the register file,
// the start/stop controller and the counters, and builds the status word.
// Assumes: DW is wide enough for the arm bits above the mode and stop fields.
module sdx_seq
    import sdx_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 3,
    parameter int LEN_W   = 12,
    parameter int CNT_W   = 12,
    parameter int TMR_W   = 16,
    parameter int TMR_RST = 'h2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          cmd_done,
    input  logic          byte_strobe,
    output logic          xfer_run,
    output logic          irq
);

    localparam int MODE_LSB = CNT_W;
    localparam int STOP_BIT = CNT_W + 2;
    localparam int ARM_LSB  = CNT_W + 6;

    logic [LEN_W-1:0] bsize, byte_cnt;
    logic [CNT_W-1:0] blk_cnt, cnt_in;
    logic [DW-1:0]    dctrl, mask;
    logic [ST_W-1:0]  status;
    logic             dctrl_wr, stat_clr, active, load, load_from_wr, done;
    logic             byte_zero, step, wr_armed, cur_armed;
    xmode_e           wr_mode, cur_mode;

    // Decodes the write-side and stored control fields.
    always_comb begin
        dctrl_wr  = wr_en && (int'(wr_addr) == A_DCTRL);
        stat_clr  = wr_en && (int'(wr_addr) == A_STAT) && wr_data[ST_DONE];
        wr_mode   = xmode_e'(wr_data[MODE_LSB +: 2]);
        cur_mode  = xmode_e'(dctrl[MODE_LSB +: 2]);
        wr_armed  = pick_arm(wr_mode, wr_data[ARM_LSB +: 3]);
        cur_armed = pick_arm(cur_mode, dctrl[ARM_LSB +: 3]);
        cnt_in    = load_from_wr ? wr_data[CNT_W-1:0] : dctrl[CNT_W-1:0];
        step      = byte_strobe && active && ((cur_mode == XM_RX) || (cur_mode == XM_TX));
    end

    // Builds the status word and outputs.
    always_comb begin
        status              = '0;
        status[ST_RUN_DATA] = active && ((cur_mode == XM_RX) || (cur_mode == XM_TX));
        status[ST_RUN_BUSY] = active && (cur_mode == XM_BUSY);
        status[ST_DONE]     = done;
        xfer_run            = active;
        irq                 = done && mask[IRQ_MASK_BIT];
    end

    sdx_regs #(
        .DW(DW), .AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W),
        .TMR_W(TMR_W), .TMR_RST(TMR_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .remain_byte(byte_cnt),
        .remain_blk(blk_cnt), .status(status), .bsize(bsize),
        .dctrl(dctrl), .mask(mask), .rd_data(rd_data)
    );

    sdx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .dctrl_wr(dctrl_wr), .wr_mode(wr_mode),
        .wr_stop(wr_data[STOP_BIT]), .wr_armed(wr_armed), .cur_mode(cur_mode),
        .cur_armed(cur_armed), .cmd_done(cmd_done), .byte_zero(byte_zero),
        .stat_clr(stat_clr), .active(active), .load(load),
        .load_from_wr(load_from_wr), .done(done)
    );

    sdx_counters #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .len_in(bsize),
        .cnt_in(cnt_in), .step(step), .byte_cnt(byte_cnt),
        .blk_cnt(blk_cnt), .byte_zero(byte_zero)
    );

endmodule

// File: rtl/sdx_seq_chk.sv
// Property checker for the transfer sequencer, bound to every sdx_seq.
// Assumes: it sees the top's internal counters, control and flags.
module sdx_seq_chk
    import sdx_pkg::*;
#(
    parameter int DW       = 32,
    parameter int LEN_W    = 12,
    parameter int CNT_W    = 12,
    parameter int STOP_BIT = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dctrl_wr,
    input logic [DW-1:0]    wr_data,
    input logic             cmd_done,
    input logic             byte_strobe,
    input logic             active,
    input logic             done,
    input xmode_e           cur_mode,
    input logic [LEN_W-1:0] byte_cnt,
    input logic [CNT_W-1:0] blk_cnt,
    input logic [LEN_W-1:0] bsize
);

    logic data_mode;
    assign data_mode = (cur_mode == XM_RX) || (cur_mode == XM_TX);

    a_r12_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dctrl_wr && wr_data[STOP_BIT]) |=> !active);

    a_r8_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (active && data_mode && byte_cnt == '0 && !dctrl_wr && !cmd_done)
        |=> (!active && done));

    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && data_mode && byte_strobe && byte_cnt > LEN_W'(1) && !dctrl_wr && !cmd_done)
        |=> (byte_cnt == $past(byte_cnt) - LEN_W'(1) && $stable(blk_cnt)));

    a_r13_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cur_mode == XM_BUSY && !dctrl_wr && !cmd_done)
        |=> (active && $stable(byte_cnt) && $stable(blk_cnt)));

    a_r5_cmd_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !dctrl_wr) |=> (byte_cnt == $past(bsize)));

endmodule

bind sdx_seq sdx_seq_chk #(
    .DW(DW), .LEN_W(LEN_W), .CNT_W(CNT_W), .STOP_BIT(STOP_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dctrl_wr(dctrl_wr), .wr_data(wr_data),
    .cmd_done(cmd_done), .byte_strobe(byte_strobe), .active(active),
    .done(done), .cur_mode(cur_mode), .byte_cnt(byte_cnt),
    .blk_cnt(blk_cnt), .bsize(bsize)
);

// File: tb/tb_sdx_seq.sv
// Scoreboard bench for sdx_seq: the driver queues expected values, a
// monitor on the falling edge compares them with the design's outputs.
module tb_sdx_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        cmd_done = 1'b0;
    logic        byte_strobe = 1'b0;
    logic        xfer_run, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    sdx_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cmd_done(cmd_done), .byte_strobe(byte_strobe),
        .xfer_run(xfer_run), .irq(irq)
    );

    // Monitor: compares queued expectations away from the active edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = sb.pop_front();
            if (it.sel < 8)       got = rd_data;
            else if (it.sel == 8) got = {31'b0, xfer_run};
            else                  got = {31'b0, irq};
            n_chk++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h",
                         it.req, it.sel, got, it.exp);
            end
        end
    end

    // sel 0..7: register read; 8: xfer_run; 9: irq.
    task automatic chk(input int sel, input logic [31:0] exp, input string req);
        item_t it;
        if (sel < 8) rd_addr = 3'(sel);
        it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_addr = 3'(a); wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic strobe(input int n);
        byte_strobe = 1'b1;
        repeat (n) @(posedge clk);
        #1 byte_strobe = 1'b0;
    endtask

    task automatic cmd();
        cmd_done = 1'b1;
        @(posedge clk); #1;
        cmd_done = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(2, 32'h0, "R1 remain");
        chk(3, 32'h0, "R1 status");
        chk(4, 32'h0, "R1 mask");
        chk(5, 32'h2000, "R1 timer");
        chk(8, 0, "R1 run");
        chk(9, 0, "R1 irq");
        // R2 register fields
        wr(0, 32'hF003);
        chk(0, 32'h3, "R2 bsize width");
        chk(7, 32'h0, "R2 unmapped");
        wr(5, 32'h12345);
        chk(5, 32'h2345, "R2 timer width");
        // R14 mode 0 write
        wr(1, 32'h0002);
        chk(8, 0, "R14 mode0 no start");
        // R3 R7 R6 R8 R9 receive, two blocks of three
        wr(4, 32'h80);
        wr(1, 32'h2002);
        chk(8, 1, "R3 rx start");
        chk(2, 32'h2003, "R7 remain layout");
        chk(3, 32'h1, "R10 data running");
        strobe(2);
        chk(2, 32'h2001, "R6 byte decrement");
        strobe(1);
        chk(2, 32'h1003, "R6 block reload");
        strobe(3);
        chk(2, 32'h0, "R6 last byte");
        chk(8, 0, "R8 run drops");
        chk(3, 32'h10, "R8 done set");
        chk(9, 1, "R9 irq high");
        wr(3, 32'h3E8);
        chk(3, 32'h10, "R11 other bits no clear");
        wr(3, 32'h10);
        chk(3, 32'h0, "R11 clear done");
        chk(9, 0, "R9 irq low");
        // R4 deferred transmit, then R12 stop
        wr(0, 32'h2);
        wr(1, 32'h103001);
        chk(8, 0, "R4 armed no start");
        chk(3, 32'h0, "R4 status idle");
        strobe(1);
        chk(2, 32'h0, "R13 idle strobe ignored");
        cmd();
        chk(8, 1, "R4 start after cmd");
        chk(2, 32'h1002, "R4 counters loaded");
        strobe(1);
        chk(2, 32'h1001, "R6 tx decrement");
        wr(1, 32'h7001);
        chk(8, 0, "R12 stop wins");
        chk(2, 32'h1001, "R12 counters hold");
        chk(3, 32'h0, "R12 no done");
        // R13 busy-wait
        wr(0, 32'h4);
        wr(1, 32'h1005);
        chk(3, 32'h2, "R10 busy running");
        strobe(3);
        chk(2, 32'h5004, "R13 busy ignores strobes");
        chk(8, 1, "R13 busy stays");
        wr(1, 32'h4000);
        chk(8, 0, "R12 stop busy");
        // R5 command load without start
        wr(1, 32'h0007);
        chk(2, 32'h5004, "R14 mode0 no load");
        cmd();
        chk(2, 32'h7004, "R5 cmd load");
        chk(8, 0, "R5 no start");
        // R8 zero block size
        wr(0, 32'h0);
        wr(1, 32'h2001);
        chk(8, 1, "R8 zero size starts");
        chk(8, 0, "R8 zero size ends");
        chk(3, 32'h10, "R8 zero size done");
        chk(9, 1, "R9 irq zero size");
        finished = 1;
        summary();
    end

endmodule